// File: doc/BRIEF.md
# Transition-Handshake Boot Packet Sender

This block brings up a mesh of processing nodes by pushing one boot packet into a spare router port. It sends the packet over an asynchronous byte channel with two-phase signalling. Each byte is presented on the data lines and then announced by one edge of the request line, rising or falling. The router answers with one edge of the acknowledge line. The block samples acknowledge through a synchroniser and waits until its level matches the request level before it offers the next byte.

A sequence starts on a start request, or on a rerun request that also carries new routing offsets. The block first waits a power-settle delay, which is about one second by default. It then drives the machine reset for a fixed number of cycles and releases it. After that it streams the packet: the X routing offset, the Y routing offset, and then the boot bytes read from a range of a synchronous boot memory. The tail line is raised with the final byte. When that byte is acknowledged, the tail line drops and a one-cycle done pulse marks the end of the packet.

Top module: `bootpkt_sender`

## Requirements
- R1: While reset is held, and afterwards until a sequence is requested, `ch_req_o`, `ch_tail_o`, `mach_rst_o`, `mem_rd_o` and `done_o` are all 0.
- R2: After a request is accepted, `mach_rst_o` stays low for exactly SETTLE_CYCLES cycles, then stays high for exactly RESET_CYCLES cycles. No byte is announced before it falls.
- R3: The packet carries the X offset first and the Y offset second. It then carries the memory bytes from the base address up to and including the last address, in rising address order. Both addresses are captured when the request is accepted. Each byte is read by a one-cycle `mem_rd_o` pulse whose data returns on `mem_data_i` in the following cycle.
- R4: `ch_data_o` is stable in the cycle before each request edge, and stays stable until the synchronised acknowledge matches the request level.
- R5: Each byte uses exactly one request edge, and both edge directions count. No further request edge occurs while an acknowledge is outstanding. `ch_ack_i` passes through SYNC_STAGES flops before it is compared with the request level.
- R6: `ch_tail_o` is 1 only while the final byte of the packet is on the channel. When that byte is acknowledged, `ch_tail_o` falls and `done_o` is 1 for exactly one cycle in the same cycle.
- R7: Both routing offsets are 0 after reset. `rerun_i` loads `rerun_x_i` and `rerun_y_i`. The loaded values are used for that sequence and for every later sequence started by `start_i`.
- R8: From acceptance until the done pulse, `start_i` and `rerun_i` are ignored. The offsets, the address range and the byte stream do not change.
- R9: When the last address is below the base address, the packet holds only the two offset bytes. The tail rides on the Y byte and no memory read is issued.
- R10: In the first cycle after a request is accepted, `ch_req_o` and `ch_tail_o` are 0, even if the previous packet left request at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sequence using the stored offsets |
| rerun_i | input | 1 | Start a sequence and load new offsets |
| rerun_x_i | input | DATA_W | X offset loaded by rerun |
| rerun_y_i | input | DATA_W | Y offset loaded by rerun |
| base_addr_i | input | ADDR_W | First boot memory address |
| last_addr_i | input | ADDR_W | Last boot memory address (inclusive) |
| mem_rd_o | output | 1 | Boot memory read strobe |
| mem_addr_o | output | ADDR_W | Boot memory read address |
| mem_data_i | input | DATA_W | Boot memory data, one cycle after the strobe |
| ch_data_o | output | DATA_W | Channel data byte |
| ch_req_o | output | 1 | Two-phase request |
| ch_ack_i | input | 1 | Two-phase acknowledge, asynchronous |
| ch_tail_o | output | 1 | Marks the final byte of the packet |
| mach_rst_o | output | 1 | Active-high machine reset pulse |
| done_o | output | 1 | One-cycle pulse when the tail byte is acknowledged |

## Verification
The hardest situation to reach is a new sequence that starts while the previous packet left the request line at 1 and acknowledge still matching it. That is where the forced clear of request meets a stale synchronised acknowledge. The stimulus table reaches it by running a three-byte packet (one memory byte) and then starting another sequence at once. A second hard case is a start or rerun that arrives while a sequence is already running. The table marks one entry so that it fires rerun, start and new addresses in the middle of the settle delay. The checks then confirm that the packet and the following one still use the earlier offsets. The bench's router model varies its acknowledge latency from vector to vector, so the data-hold and no-early-request rules are tested with waits of several lengths.

// File: rtl/bootpkt_pkg.sv
package bootpkt_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SETTLE,
      SQ_RESET,
      SQ_PUT,
      SQ_FETCH,
      SQ_CAPT,
      SQ_WAIT
   } seq_t;

   typedef enum logic [1:0] {
      PH_X,
      PH_Y,
      PH_MEM
   } phase_t;

endpackage

// File: rtl/bps_ack_sync.sv
module bps_ack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bps_ack_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], async_i};
   end

   assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/bps_delay_timer.sv
module bps_delay_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   if (CNT_W < 1) begin : g_bad_width
      $error("bps_delay_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= load_val_i;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);

endmodule

// File: rtl/bps_chan_drv.sv
module bps_chan_drv #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              put_i,
   input  logic [DATA_W-1:0] put_data_i,
   input  logic              put_last_i,
   input  logic              ack_s_i,
   output logic [DATA_W-1:0] data_o,
   output logic              req_o,
   output logic              tail_o,
   output logic              acked_o,
   output logic              end_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("bps_chan_drv: DATA_W must be positive");
   end

   logic armed;
   logic waiting;
   logic level_match;

   assign level_match = (ack_s_i == req_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         req_o   <= 1'b0;
         tail_o  <= 1'b0;
         armed   <= 1'b0;
         waiting <= 1'b0;
         acked_o <= 1'b0;
         end_o   <= 1'b0;
      end else begin
         acked_o <= 1'b0;
         end_o   <= 1'b0;
         if (clear_i) begin
            req_o   <= 1'b0;
            tail_o  <= 1'b0;
            armed   <= 1'b0;
            waiting <= 1'b0;
         end else if (put_i) begin
            data_o <= put_data_i;
            tail_o <= put_last_i;
            armed  <= 1'b1;
         end else if (armed && level_match) begin
            req_o   <= ~req_o;
            armed   <= 1'b0;
            waiting <= 1'b1;
         end else if (waiting && level_match) begin
            waiting <= 1'b0;
            acked_o <= 1'b1;
            if (tail_o) begin
               tail_o <= 1'b0;
               end_o  <= 1'b1;
            end
         end
      end
   end

   a_r5_no_early_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o != ack_s_i) |=> $stable(req_o));

   a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o != ack_s_i) |=> $stable(data_o));

   a_r4_data_before_req: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_o) |-> $stable(data_o));

   a_r6_tail_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tail_o) && !$past(clear_i) |-> end_o);

   a_r6_done_tail: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |-> $fell(tail_o));

endmodule

// File: rtl/bootpkt_sender.sv
module bootpkt_sender #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned SETTLE_CYCLES = 50_000_000,
   parameter int unsigned RESET_CYCLES  = 1000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rerun_i,
   input  logic [DATA_W-1:0] rerun_x_i,
   input  logic [DATA_W-1:0] rerun_y_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [ADDR_W-1:0] last_addr_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] ch_data_o,
   output logic              ch_req_o,
   input  logic              ch_ack_i,
   output logic              ch_tail_o,
   output logic              mach_rst_o,
   output logic              done_o
);
   import bootpkt_pkg::*;

   localparam int unsigned TMAX  = (SETTLE_CYCLES > RESET_CYCLES) ? SETTLE_CYCLES : RESET_CYCLES;
   localparam int unsigned TMR_W = $clog2(TMAX + 1);

   if (SETTLE_CYCLES < 1 || RESET_CYCLES < 1) begin : g_bad_delay
      $error("bootpkt_sender: delays must be at least one cycle");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("bootpkt_sender: widths must be positive");
   end

   seq_t              state;
   phase_t            phase;
   logic [DATA_W-1:0] off_x;
   logic [DATA_W-1:0] off_y;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] last_q;
   logic              empty_q;

   logic              accept;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              ack_s;
   logic              put;
   logic [DATA_W-1:0] put_data;
   logic              put_last;
   logic              acked;
   logic              pkt_end;

   assign accept = (state == SQ_IDLE) && (start_i || rerun_i);

   // shared delay counter: settle first, then reset pulse
   assign tmr_load = accept || ((state == SQ_SETTLE) && tmr_zero);
   assign tmr_val  = accept ? TMR_W'(SETTLE_CYCLES - 1) : TMR_W'(RESET_CYCLES - 1);

   bps_delay_timer #(.CNT_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   bps_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ch_ack_i),
      .sync_o  (ack_s)
   );

   assign put      = (state == SQ_PUT) || (state == SQ_CAPT);
   assign put_data = (state == SQ_CAPT) ? mem_data_i :
                     (phase == PH_X)    ? off_x : off_y;
   assign put_last = ((state == SQ_PUT) && (phase == PH_Y) && empty_q) ||
                     ((state == SQ_CAPT) && (addr_q == last_q));

   bps_chan_drv #(.DATA_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (accept),
      .put_i      (put),
      .put_data_i (put_data),
      .put_last_i (put_last),
      .ack_s_i    (ack_s),
      .data_o     (ch_data_o),
      .req_o      (ch_req_o),
      .tail_o     (ch_tail_o),
      .acked_o    (acked),
      .end_o      (pkt_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         phase   <= PH_X;
         off_x   <= '0;
         off_y   <= '0;
         addr_q  <= '0;
         last_q  <= '0;
         empty_q <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (accept) begin
                  if (rerun_i) begin
                     off_x <= rerun_x_i;
                     off_y <= rerun_y_i;
                  end
                  addr_q  <= base_addr_i;
                  last_q  <= last_addr_i;
                  empty_q <= (last_addr_i < base_addr_i);
                  state   <= SQ_SETTLE;
               end
            end
            SQ_SETTLE: if (tmr_zero) state <= SQ_RESET;
            SQ_RESET: begin
               if (tmr_zero) begin
                  phase <= PH_X;
                  state <= SQ_PUT;
               end
            end
            SQ_PUT:   state <= SQ_WAIT;
            SQ_FETCH: state <= SQ_CAPT;
            SQ_CAPT:  state <= SQ_WAIT;
            SQ_WAIT: begin
               if (acked) begin
                  if (pkt_end) begin
                     state <= SQ_IDLE;
                  end else begin
                     unique case (phase)
                        PH_X: begin
                           phase <= PH_Y;
                           state <= SQ_PUT;
                        end
                        PH_Y: begin
                           phase <= PH_MEM;
                           state <= SQ_FETCH;
                        end
                        default: begin
                           addr_q <= addr_q + 1'b1;
                           state  <= SQ_FETCH;
                        end
                     endcase
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign mem_rd_o   = (state == SQ_FETCH);
   assign mem_addr_o = addr_q;
   assign mach_rst_o = (state == SQ_RESET);
   assign done_o     = pkt_end;

   // length of the most recent machine reset pulse
   logic [TMR_W:0] rst_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rst_run <= '0;
      else if (mach_rst_o) rst_run <= rst_run + 1'b1;
      else                 rst_run <= '0;
   end

   a_r2_reset_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mach_rst_o) |-> (rst_run == (TMR_W+1)'(RESET_CYCLES)));

   a_r2_no_byte_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      mach_rst_o |=> $stable(ch_req_o));

   a_r8_offsets_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SQ_IDLE) |=> ($stable(off_x) && $stable(off_y) && $stable(last_q)));

   a_r9_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_q && state != SQ_IDLE) |-> !mem_rd_o);

   a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!ch_req_o && !ch_tail_o));

endmodule

// File: tb/bootpkt_sender_bench.sv
module bootpkt_sender_bench;

   localparam int SET_C = 20;
   localparam int RST_C = 5;
   localparam int AW    = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          rerun_i = 1'b0;
   logic [7:0]    rerun_x_i = '0;
   logic [7:0]    rerun_y_i = '0;
   logic [AW-1:0] base_addr_i = '0;
   logic [AW-1:0] last_addr_i = '0;
   logic          mem_rd_o;
   logic [AW-1:0] mem_addr_o;
   logic [7:0]    mem_data_i;
   logic [7:0]    ch_data_o;
   logic          ch_req_o;
   logic          ch_ack_i = 1'b0;
   logic          ch_tail_o;
   logic          mach_rst_o;
   logic          done_o;

   always #2.5 clk = ~clk;

   bootpkt_sender #(
      .DATA_W(8), .ADDR_W(AW), .SETTLE_CYCLES(SET_C),
      .RESET_CYCLES(RST_C), .SYNC_STAGES(2)
   ) u_bootpkt_sender (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rerun_i(rerun_i),
      .rerun_x_i(rerun_x_i), .rerun_y_i(rerun_y_i),
      .base_addr_i(base_addr_i), .last_addr_i(last_addr_i),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
      .ch_data_o(ch_data_o), .ch_req_o(ch_req_o), .ch_ack_i(ch_ack_i),
      .ch_tail_o(ch_tail_o), .mach_rst_o(mach_rst_o), .done_o(done_o)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] memf(input logic [AW-1:0] a);
      return (a[7:0] * 8'd7) + {4'h0, a[11:8]} + 8'h3d;
   endfunction

   // boot memory: one-cycle read latency
   always_ff @(posedge clk) if (mem_rd_o) mem_data_i <= memf(mem_addr_o);

   // router model
   logic [7:0] rx_data [64];
   bit         rx_tail [64];
   int  rx_n = 0;
   int  done_cnt = 0;
   int  rd_cnt = 0;
   int  cur_lat = 0;
   int  lat_cnt = 0;
   bit  armed = 1'b0;
   bit  pend = 1'b0;
   logic last_req = 1'b0;

   always @(negedge clk) begin
      if (done_o) done_cnt++;
      if (mem_rd_o) rd_cnt++;
      if (!rst_n) begin
         ch_ack_i = 1'b0; armed = 1'b0; pend = 1'b0; last_req = 1'b0;
      end else if (mach_rst_o) begin
         ch_ack_i = 1'b0; armed = 1'b1; pend = 1'b0; last_req = ch_req_o;
      end else if (armed) begin
         if (ch_req_o != last_req) begin
            chk(!pend, "R5 request edge while acknowledge outstanding", 1, 0);
            if (rx_n < 64) begin
               rx_data[rx_n] = ch_data_o;
               rx_tail[rx_n] = ch_tail_o;
               rx_n++;
            end
            last_req = ch_req_o;
            pend = 1'b1;
            lat_cnt = cur_lat;
         end else if (pend) begin
            if (lat_cnt == 0) begin
               chk(ch_data_o == rx_data[rx_n-1], "R4 data held until acknowledge",
                   ch_data_o, rx_data[rx_n-1]);
               ch_ack_i = last_req;
               pend = 1'b0;
            end else begin
               lat_cnt--;
            end
         end
         if (done_o) armed = 1'b0;
      end else begin
         last_req = ch_req_o;
      end
   end

   // kind[0]=rerun, kind[1]=intrusion during settle; lat; x; y; base; last
   localparam int NV = 8;
   localparam logic [47:0] VECS [NV] = '{
      {4'h0, 4'd0, 8'hAA, 8'hBB, 12'h010, 12'h013},
      {4'h1, 4'd2, 8'h03, 8'h05, 12'h100, 12'h100},
      {4'h0, 4'd1, 8'h09, 8'h09, 12'h020, 12'h027},
      {4'h1, 4'd3, 8'hFF, 8'h80, 12'hFFE, 12'hFFF},
      {4'h0, 4'd0, 8'h11, 8'h22, 12'h050, 12'h04F},
      {4'h1, 4'd4, 8'h01, 8'h02, 12'h000, 12'h002},
      {4'h2, 4'd1, 8'h44, 8'h55, 12'h030, 12'h032},
      {4'h0, 4'd0, 8'h00, 8'h00, 12'h040, 12'h041}
   };

   logic [7:0] mx = 8'h00;
   logic [7:0] my = 8'h00;

   task automatic run_vec(input logic [47:0] v);
      logic [3:0]    kind = v[47:44];
      int            lat  = int'(v[43:40]);
      logic [7:0]    vx   = v[39:32];
      logic [7:0]    vy   = v[31:24];
      logic [AW-1:0] vb   = v[23:12];
      logic [AW-1:0] vl   = v[11:0];
      int n_mem, cnt, hc, w;
      string otag;
      if (kind[0]) begin mx = vx; my = vy; end
      n_mem = (vl >= vb) ? int'(vl - vb) + 1 : 0;
      otag = kind[1] ? "R8" : "R7";
      rx_n = 0; done_cnt = 0; rd_cnt = 0; cur_lat = lat;
      @(negedge clk);
      base_addr_i = vb; last_addr_i = vl; rerun_x_i = vx; rerun_y_i = vy;
      if (kind[0]) rerun_i = 1'b1; else start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; rerun_i = 1'b0;
      chk(!ch_req_o && !ch_tail_o, "R10 request and tail cleared at start",
          {ch_req_o, ch_tail_o}, 0);
      cnt = 0;
      while (!mach_rst_o && cnt < 1000) begin
         cnt++;
         if (kind[1] && cnt == 2) begin
            rerun_i = 1'b1; start_i = 1'b1; rerun_x_i = 8'h77; rerun_y_i = 8'h66;
            base_addr_i = '0; last_addr_i = 12'h005;
         end else begin
            rerun_i = 1'b0; start_i = 1'b0;
         end
         @(negedge clk);
      end
      rerun_i = 1'b0; start_i = 1'b0;
      chk(cnt == SET_C, "R2 settle length", cnt, SET_C);
      hc = 0;
      while (mach_rst_o && hc < 1000) begin hc++; @(negedge clk); end
      chk(hc == RST_C, "R2 reset pulse length", hc, RST_C);
      w = 0;
      while (done_cnt == 0 && w < 5000) begin w++; @(negedge clk); end
      repeat (6) @(negedge clk);
      chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
      chk(rx_n == 2 + n_mem, "R3 byte count", rx_n, 2 + n_mem);
      chk(rd_cnt == n_mem, (n_mem == 0) ? "R9 no memory read" : "R3 memory reads",
          rd_cnt, n_mem);
      for (int i = 0; i < rx_n && i < 64; i++) begin
         logic [7:0] e;
         if (i == 0)      e = mx;
         else if (i == 1) e = my;
         else             e = memf(vb + AW'(i - 2));
         chk(rx_data[i] == e, (i < 2) ? otag : "R3", rx_data[i], e);
         chk(rx_tail[i] == (i == rx_n - 1),
             (n_mem == 0) ? "R9 tail on Y byte" : "R6 tail only on final byte",
             rx_tail[i], (i == rx_n - 1));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({ch_req_o, ch_tail_o, mach_rst_o, mem_rd_o, done_o} == '0,
          "R1 outputs idle in reset", {ch_req_o, ch_tail_o, mach_rst_o, mem_rd_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk({ch_req_o, ch_tail_o, mach_rst_o, mem_rd_o, done_o} == '0,
          "R1 outputs idle after reset", {ch_req_o, ch_tail_o, mach_rst_o, mem_rd_o, done_o}, 0);

      for (int k = 0; k < NV; k++) run_vec(VECS[k]);

      // reset in the middle of a sequence, then offsets back to zero
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (SET_C + 2) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk({ch_req_o, ch_tail_o, mach_rst_o, done_o} == '0,
          "R1 outputs cleared by reset mid-sequence", {ch_req_o, ch_tail_o, mach_rst_o, done_o}, 0);
      rst_n = 1'b1;
      mx = 8'h00; my = 8'h00;
      repeat (3) @(negedge clk);
      run_vec({4'h0, 4'd2, 8'h5A, 8'hA5, 12'h060, 12'h060});

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule